// File: doc/BRIEF.md
# Quadrature Encoder Counter Core

This block counts the motion of an incremental encoder on one channel. It samples the encoder's two phase lines and its index line through a synchronizer. It turns edges into up or down steps according to a selectable counting function, and keeps a 24-bit count in a register. The count is then wrapped, clamped or frozen against a host-written preset register, as the count mode selects. Two toggle flags mark every overflow and underflow, and their exclusive-or extends the count to a 25th bit. A direction flag records the sense of the latest step. A sticky noise flag records any sample in which both phases moved at once.

A host configures the block through three small fields: a mode field, an input-control field and an index-control field. It drives single-cycle strobes to write the preset, copy the preset into the count, zero the count, and clear the toggle flags or the noise flag. An index edge of the selected polarity can also copy the preset into the count. In synchronous index operation that copy is further qualified by the encoder phase.

Top module: `qenc_counter_core`

## Requirements
- R1: After reset, the count, the carry and borrow flags, the direction flag and the noise flag are all 0. A zero strobe clears the count at the next clock edge.
- R2: With `mode_cfg[4:3]` = 00 (pulse/direction), each rising edge of A is one step, up when B is high and down when B is low. Falling edges of A and changes of B alone do not count.
- R3: With `mode_cfg[4:3]` = 01 (x1), a rising edge of A while B is low counts up and a falling edge of A while B is low counts down. No other edge counts.
- R4: With `mode_cfg[4:3]` = 10 (x2), every edge of A counts: up when A and B differ after the edge, down when they are equal.
- R5: With `mode_cfg[4:3]` = 11 (x4), every single-line edge counts. The forward cycle of (A,B) is 00, 10, 11, 01, 00, and it counts up; the reverse cycle counts down.
- R6: With `mode_cfg[2:1]` = 0 (free-running), the count wraps from 0xFFFFFF to 0 and toggles the carry flag, and wraps from 0 to 0xFFFFFF and toggles the borrow flag. carry XOR borrow is the 25th count bit. A flag-clear strobe zeroes both flags.
- R7: With `mode_cfg[2:1]` = 1 (clamp), an up step at or above the preset holds the count and toggles carry. A down step at 0 holds the count and toggles borrow.
- R8: With `mode_cfg[2:1]` = 2 (one-shot), the first wrap past 0xFFFFFF or below 0 toggles the flag and then freezes the count. The count stays frozen until a load strobe, a zero strobe or an index load.
- R9: With `mode_cfg[2:1]` = 3 (modulo), an up step from the preset gives 0 and toggles carry. A down step from 0 gives the preset and toggles borrow.
- R10: The direction output is 1 after an up step and 0 after a down step, including steps that a count mode blocks.
- R11: With `io_cfg[0]` = 0 the phase inputs produce no steps, so the count holds.
- R12: With `io_cfg[1]` = 0, an index edge copies the preset into the count. The edge is rising for `idx_cfg[1]` = 1 and falling for `idx_cfg[1]` = 0. With `io_cfg[1]` = 1, index edges have no effect.
- R13: When `idx_cfg[0]` = 1 and a quadrature function (x1, x2 or x4) is selected, an index load happens only while the synchronized A and B are both low. In pulse/direction mode, `idx_cfg[0]` is overridden and loads are unqualified.
- R14: A sample in which A and B both change is no step and sets the noise flag. The noise flag stays set until an error-clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Encoder index (asynchronous) |
| mode_cfg | input | 4 | Bits [4:3] counting function, bits [2:1] count mode |
| io_cfg | input | 2 | Bit 0 phase-input enable, bit 1 active-low index preset enable |
| idx_cfg | input | 2 | Bit 0 synchronous index, bit 1 index polarity (1 = rising) |
| preset_wr | input | 1 | Write strobe for the preset register |
| preset_din | input | 24 | Preset value to write |
| load_stb | input | 1 | Copy the preset into the count |
| zero_stb | input | 1 | Clear the count |
| flag_clr_stb | input | 1 | Clear the carry and borrow flags |
| err_clr_stb | input | 1 | Clear the noise flag |
| count_o | output | 24 | Current count |
| carry_o | output | 1 | Carry toggle flag |
| borrow_o | output | 1 | Borrow toggle flag |
| dir_up_o | output | 1 | 1 when the latest step was upward |
| noise_err_o | output | 1 | Sticky simultaneous-edge flag |

## Verification
The bench walks each counting function through forward and reverse phase sequences, including the reversal points. A decoder that read B at the wrong moment would count half-steps twice or lose them. It drives the count across both 24-bit boundaries, and against the preset in the clamp and modulo modes. A wrong comparison would overshoot the preset, or wrap where it should hold. In one-shot mode it steps again after the first wrap and then reloads, which catches a freeze that never clears or one that never engages. It applies index edges of both polarities with the load enabled and disabled, and with the phase off and on 00 in synchronous mode. It also applies a simultaneous two-line change, which a careless decoder would take for a step.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   // counting function, decoded from mode field bits [4:3]
   typedef enum logic [1:0] {
      FN_PULSE = 2'b00,
      FN_X1    = 2'b01,
      FN_X2    = 2'b10,
      FN_X4    = 2'b11
   } qenc_func_e;

   // count mode, decoded from mode field bits [2:1]
   typedef enum logic [1:0] {
      CM_FREE    = 2'd0,
      CM_CLAMP   = 2'd1,
      CM_ONESHOT = 2'd2,
      CM_WRAPN   = 2'd3
   } qenc_cmode_e;

   typedef struct packed {
      logic up;
      logic dn;
      logic glitch;
   } qenc_step_t;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] prev_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qenc_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("qenc_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;
   logic [WIDTH-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign q_o    = chain_q[STAGES-1];
   assign prev_o = prev_q;

endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
   import qenc_pkg::*;
#(
   parameter bit GLITCH_CHECK = 1'b1
) (
   input  logic       a_i,
   input  logic       b_i,
   input  logic       a_prev_i,
   input  logic       b_prev_i,
   input  qenc_func_e func_i,
   input  logic       enable_i,
   output qenc_step_t step_o
);

   logic a_chg, b_chg, both_chg, lead;
   logic up_raw, dn_raw, err_raw;

   always_comb begin
      a_chg    = a_i ^ a_prev_i;
      b_chg    = b_i ^ b_prev_i;
      both_chg = a_chg & b_chg;
      lead     = a_i ^ b_i;
      up_raw   = 1'b0;
      dn_raw   = 1'b0;
      if (!both_chg) begin
         case (func_i)
            FN_PULSE: begin
               if (a_i & ~a_prev_i) begin
                  up_raw = b_i;
                  dn_raw = ~b_i;
               end
            end
            FN_X1: begin
               if (a_chg & ~b_i) begin
                  up_raw = a_i;
                  dn_raw = ~a_i;
               end
            end
            FN_X2: begin
               if (a_chg) begin
                  up_raw = lead;
                  dn_raw = ~lead;
               end
            end
            default: begin
               if (a_chg) begin
                  up_raw = lead;
                  dn_raw = ~lead;
               end else if (b_chg) begin
                  up_raw = ~lead;
                  dn_raw = lead;
               end
            end
         endcase
      end
   end

   generate
      if (GLITCH_CHECK) begin : g_glitch_on
         assign err_raw = both_chg;
      end else begin : g_glitch_off
         assign err_raw = 1'b0;
      end
   endgenerate

   assign step_o.up     = enable_i & up_raw;
   assign step_o.dn     = enable_i & dn_raw;
   assign step_o.glitch = enable_i & err_raw;

endmodule

// File: rtl/qenc_index_ctl.sv
module qenc_index_ctl
   import qenc_pkg::*;
(
   input  logic       idx_i,
   input  logic       idx_prev_i,
   input  logic       a_i,
   input  logic       b_i,
   input  qenc_func_e func_i,
   input  logic [1:0] idx_cfg_i,
   input  logic       preset_on_idx_n_i,
   output logic       idx_load_o
);

   logic edge_hit, sync_req, phase_ok;

   // bit 1 picks the active edge, bit 0 asks for phase qualification
   assign edge_hit   = idx_cfg_i[1] ? (idx_i & ~idx_prev_i) : (~idx_i & idx_prev_i);
   assign sync_req   = idx_cfg_i[0] & (func_i != FN_PULSE);
   assign phase_ok   = ~sync_req | (~a_i & ~b_i);
   assign idx_load_o = edge_hit & phase_ok & ~preset_on_idx_n_i;

endmodule

// File: rtl/qenc_count_engine.sv
module qenc_count_engine
   import qenc_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  qenc_step_t       step_i,
   input  qenc_cmode_e      cmode_i,
   input  logic             preset_wr_i,
   input  logic [CNT_W-1:0] preset_din_i,
   input  logic             load_i,
   input  logic             zero_i,
   input  logic             flag_clr_i,
   input  logic             err_clr_i,
   input  logic             idx_load_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             carry_o,
   output logic             borrow_o,
   output logic             dir_o,
   output logic             err_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, preset_q, cnt_nxt;
   logic             carry_q, borrow_q, dir_q, err_q, frozen_q;
   logic             carry_flip, borrow_flip, freeze_set;
   logic             at_zero, at_top, hit_limit, reload;

   assign reload    = zero_i | load_i | idx_load_i;
   assign at_zero   = (cnt_q == '0);
   assign at_top    = (cnt_q == CNT_MAX);
   assign hit_limit = (cnt_q >= preset_q);

   always_comb begin
      cnt_nxt     = cnt_q;
      carry_flip  = 1'b0;
      borrow_flip = 1'b0;
      freeze_set  = 1'b0;
      if (step_i.up) begin
         case (cmode_i)
            CM_CLAMP: begin
               if (hit_limit) carry_flip = 1'b1;
               else           cnt_nxt    = cnt_q + CNT_ONE;
            end
            CM_WRAPN: begin
               if (hit_limit) begin
                  cnt_nxt    = '0;
                  carry_flip = 1'b1;
               end else begin
                  cnt_nxt = cnt_q + CNT_ONE;
               end
            end
            CM_ONESHOT: begin
               if (!frozen_q) begin
                  cnt_nxt = cnt_q + CNT_ONE;
                  if (at_top) begin
                     carry_flip = 1'b1;
                     freeze_set = 1'b1;
                  end
               end
            end
            default: begin
               cnt_nxt    = cnt_q + CNT_ONE;
               carry_flip = at_top;
            end
         endcase
      end else if (step_i.dn) begin
         case (cmode_i)
            CM_CLAMP: begin
               if (at_zero) borrow_flip = 1'b1;
               else         cnt_nxt     = cnt_q - CNT_ONE;
            end
            CM_WRAPN: begin
               if (at_zero) begin
                  cnt_nxt     = preset_q;
                  borrow_flip = 1'b1;
               end else begin
                  cnt_nxt = cnt_q - CNT_ONE;
               end
            end
            CM_ONESHOT: begin
               if (!frozen_q) begin
                  cnt_nxt = cnt_q - CNT_ONE;
                  if (at_zero) begin
                     borrow_flip = 1'b1;
                     freeze_set  = 1'b1;
                  end
               end
            end
            default: begin
               cnt_nxt     = cnt_q - CNT_ONE;
               borrow_flip = at_zero;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         preset_q <= '0;
         carry_q  <= 1'b0;
         borrow_q <= 1'b0;
         dir_q    <= 1'b0;
         err_q    <= 1'b0;
         frozen_q <= 1'b0;
      end else begin
         if (preset_wr_i) preset_q <= preset_din_i;

         if (zero_i) begin
            cnt_q    <= '0;
            frozen_q <= 1'b0;
         end else if (load_i | idx_load_i) begin
            cnt_q    <= preset_q;
            frozen_q <= 1'b0;
         end else begin
            cnt_q <= cnt_nxt;
            if (freeze_set) frozen_q <= 1'b1;
         end

         if (flag_clr_i) begin
            carry_q  <= 1'b0;
            borrow_q <= 1'b0;
         end else if (!reload) begin
            carry_q  <= carry_q ^ carry_flip;
            borrow_q <= borrow_q ^ borrow_flip;
         end

         if (!reload && step_i.up)      dir_q <= 1'b1;
         else if (!reload && step_i.dn) dir_q <= 1'b0;

         if (err_clr_i)          err_q <= 1'b0;
         else if (step_i.glitch) err_q <= 1'b1;
      end
   end

   assign cnt_o    = cnt_q;
   assign carry_o  = carry_q;
   assign borrow_o = borrow_q;
   assign dir_o    = dir_q;
   assign err_o    = err_q;

   // R6
   flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_clr_i |=> !((carry_q != $past(carry_q)) && (borrow_q != $past(borrow_q))));

   // R7
   clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmode_i == CM_CLAMP && step_i.up && !reload && cnt_q >= preset_q) |=> $stable(cnt_q));

   // R8
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmode_i == CM_ONESHOT && frozen_q && !reload) |=> $stable(cnt_q));

   // R9
   modn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmode_i == CM_WRAPN && step_i.up && !reload && !flag_clr_i && cnt_q == preset_q)
      |=> (cnt_q == '0 && carry_q != $past(carry_q)));

   // R14
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr_i) |=> err_q);

endmodule

// File: rtl/qenc_counter_core.sv
module qenc_counter_core
   import qenc_pkg::*;
#(
   parameter int CNT_W        = 24,
   parameter int SYNC_STAGES  = 2,
   parameter bit GLITCH_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             enc_idx,
   input  logic [4:1]       mode_cfg,
   input  logic [1:0]       io_cfg,
   input  logic [1:0]       idx_cfg,
   input  logic             preset_wr,
   input  logic [CNT_W-1:0] preset_din,
   input  logic             load_stb,
   input  logic             zero_stb,
   input  logic             flag_clr_stb,
   input  logic             err_clr_stb,
   output logic [CNT_W-1:0] count_o,
   output logic             carry_o,
   output logic             borrow_o,
   output logic             dir_up_o,
   output logic             noise_err_o
);

   localparam int LINES = 3;

   generate
      if (CNT_W < 4) begin : g_bad_cnt_w
         $error("qenc_counter_core: CNT_W must be at least 4");
      end
   endgenerate

   logic [LINES-1:0] line_s, line_p;
   qenc_func_e       func;
   qenc_cmode_e      cmode;
   qenc_step_t       step;
   logic             idx_load;

   assign func  = qenc_func_e'(mode_cfg[4:3]);
   assign cmode = qenc_cmode_e'(mode_cfg[2:1]);

   // line order: [0] A, [1] B, [2] index
   qenc_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    ({enc_idx, enc_b, enc_a}),
      .q_o    (line_s),
      .prev_o (line_p)
   );

   qenc_step_decode #(
      .GLITCH_CHECK (GLITCH_CHECK)
   ) decode_i (
      .a_i      (line_s[0]),
      .b_i      (line_s[1]),
      .a_prev_i (line_p[0]),
      .b_prev_i (line_p[1]),
      .func_i   (func),
      .enable_i (io_cfg[0]),
      .step_o   (step)
   );

   qenc_index_ctl index_i (
      .idx_i             (line_s[2]),
      .idx_prev_i        (line_p[2]),
      .a_i               (line_s[0]),
      .b_i               (line_s[1]),
      .func_i            (func),
      .idx_cfg_i         (idx_cfg),
      .preset_on_idx_n_i (io_cfg[1]),
      .idx_load_o        (idx_load)
   );

   qenc_count_engine #(
      .CNT_W (CNT_W)
   ) engine_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .step_i       (step),
      .cmode_i      (cmode),
      .preset_wr_i  (preset_wr),
      .preset_din_i (preset_din),
      .load_i       (load_stb),
      .zero_i       (zero_stb),
      .flag_clr_i   (flag_clr_stb),
      .err_clr_i    (err_clr_stb),
      .idx_load_i   (idx_load),
      .cnt_o        (count_o),
      .carry_o      (carry_o),
      .borrow_o     (borrow_o),
      .dir_o        (dir_up_o),
      .err_o        (noise_err_o)
   );

   // R11
   ab_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_cfg[0] && !zero_stb && !load_stb && !idx_load) |=> $stable(count_o));

   // R14
   glitch_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step.glitch |-> !(step.up || step.dn));

endmodule

// File: tb/qenc_counter_core_tb.sv
module qenc_counter_core_tb_top;

   localparam int CW   = 24;
   localparam int NVEC = 41;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          enc_a, enc_b, enc_idx;
   logic [4:1]    mode_cfg;
   logic [1:0]    io_cfg, idx_cfg;
   logic          preset_wr, load_stb, zero_stb, flag_clr_stb, err_clr_stb;
   logic [CW-1:0] preset_din;
   logic [CW-1:0] count_o;
   logic          carry_o, borrow_o, dir_up_o, noise_err_o;

   int n_chk  = 0;
   int n_fail = 0;
   logic [1:0] pos = 2'd0;

   always #5 clk = ~clk;

   qenc_counter_core dut_i (
      .clk (clk), .rst_n (rst_n),
      .enc_a (enc_a), .enc_b (enc_b), .enc_idx (enc_idx),
      .mode_cfg (mode_cfg), .io_cfg (io_cfg), .idx_cfg (idx_cfg),
      .preset_wr (preset_wr), .preset_din (preset_din),
      .load_stb (load_stb), .zero_stb (zero_stb),
      .flag_clr_stb (flag_clr_stb), .err_clr_stb (err_clr_stb),
      .count_o (count_o), .carry_o (carry_o), .borrow_o (borrow_o),
      .dir_up_o (dir_up_o), .noise_err_o (noise_err_o)
   );

   // {zero_first, func[1:0], a, b, expected count[23:0], expected dir}
   localparam logic [29:0] VEC [NVEC] = '{
      {1'b1, 2'b00, 1'b0, 1'b1, 24'd0, 1'b0},
      {1'b0, 2'b00, 1'b1, 1'b1, 24'd1, 1'b1},
      {1'b0, 2'b00, 1'b0, 1'b1, 24'd1, 1'b1},
      {1'b0, 2'b00, 1'b1, 1'b1, 24'd2, 1'b1},
      {1'b0, 2'b00, 1'b0, 1'b1, 24'd2, 1'b1},
      {1'b0, 2'b00, 1'b0, 1'b0, 24'd2, 1'b1},
      {1'b0, 2'b00, 1'b1, 1'b0, 24'd1, 1'b0},
      {1'b0, 2'b00, 1'b0, 1'b0, 24'd1, 1'b0},
      {1'b1, 2'b01, 1'b0, 1'b0, 24'd0, 1'b0},
      {1'b0, 2'b01, 1'b1, 1'b0, 24'd1, 1'b1},
      {1'b0, 2'b01, 1'b1, 1'b1, 24'd1, 1'b1},
      {1'b0, 2'b01, 1'b0, 1'b1, 24'd1, 1'b1},
      {1'b0, 2'b01, 1'b0, 1'b0, 24'd1, 1'b1},
      {1'b0, 2'b01, 1'b1, 1'b0, 24'd2, 1'b1},
      {1'b0, 2'b01, 1'b0, 1'b0, 24'd1, 1'b0},
      {1'b0, 2'b01, 1'b0, 1'b1, 24'd1, 1'b0},
      {1'b0, 2'b01, 1'b1, 1'b1, 24'd1, 1'b0},
      {1'b0, 2'b01, 1'b1, 1'b0, 24'd1, 1'b0},
      {1'b0, 2'b01, 1'b0, 1'b0, 24'd0, 1'b0},
      {1'b1, 2'b10, 1'b0, 1'b0, 24'd0, 1'b0},
      {1'b0, 2'b10, 1'b1, 1'b0, 24'd1, 1'b1},
      {1'b0, 2'b10, 1'b1, 1'b1, 24'd1, 1'b1},
      {1'b0, 2'b10, 1'b0, 1'b1, 24'd2, 1'b1},
      {1'b0, 2'b10, 1'b0, 1'b0, 24'd2, 1'b1},
      {1'b0, 2'b10, 1'b1, 1'b0, 24'd3, 1'b1},
      {1'b0, 2'b10, 1'b0, 1'b0, 24'd2, 1'b0},
      {1'b0, 2'b10, 1'b0, 1'b1, 24'd2, 1'b0},
      {1'b0, 2'b10, 1'b1, 1'b1, 24'd1, 1'b0},
      {1'b0, 2'b10, 1'b0, 1'b1, 24'd2, 1'b1},
      {1'b0, 2'b10, 1'b0, 1'b0, 24'd2, 1'b1},
      {1'b1, 2'b11, 1'b0, 1'b0, 24'd0, 1'b0},
      {1'b0, 2'b11, 1'b1, 1'b0, 24'd1, 1'b1},
      {1'b0, 2'b11, 1'b1, 1'b1, 24'd2, 1'b1},
      {1'b0, 2'b11, 1'b0, 1'b1, 24'd3, 1'b1},
      {1'b0, 2'b11, 1'b0, 1'b0, 24'd4, 1'b1},
      {1'b0, 2'b11, 1'b0, 1'b1, 24'd3, 1'b0},
      {1'b0, 2'b11, 1'b1, 1'b1, 24'd2, 1'b0},
      {1'b0, 2'b11, 1'b1, 1'b0, 24'd1, 1'b0},
      {1'b0, 2'b11, 1'b0, 1'b0, 24'd0, 1'b0},
      {1'b0, 2'b11, 1'b0, 1'b1, 24'hFFFFFF, 1'b0},
      {1'b0, 2'b11, 1'b0, 1'b0, 24'd0, 1'b1}
   };

   function automatic string req_of(input logic [1:0] f);
      case (f)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive_ab(input logic na, input logic nb);
      @(negedge clk);
      enc_a = na;
      enc_b = nb;
      settle();
   endtask

   task automatic drive_idx(input logic v);
      @(negedge clk);
      enc_idx = v;
      settle();
   endtask

   // 0 zero, 1 load, 2 flag clear, 3 error clear
   task automatic strobe(input int which);
      @(negedge clk);
      case (which)
         0: zero_stb     = 1'b1;
         1: load_stb     = 1'b1;
         2: flag_clr_stb = 1'b1;
         default: err_clr_stb = 1'b1;
      endcase
      @(negedge clk);
      zero_stb = 1'b0; load_stb = 1'b0; flag_clr_stb = 1'b0; err_clr_stb = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_preset(input logic [CW-1:0] v);
      @(negedge clk);
      preset_wr = 1'b1;
      preset_din = v;
      @(negedge clk);
      preset_wr = 1'b0;
   endtask

   // x4 gray position: 0=00, 1=10, 2=11, 3=01 as (A,B)
   task automatic step(input bit up);
      pos = up ? pos + 2'd1 : pos - 2'd1;
      drive_ab(pos[0] ^ pos[1], pos[1]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [29:0] v;
      rst_n = 1'b0;
      enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b0;
      mode_cfg = 4'b0000; io_cfg = 2'b11; idx_cfg = 2'b00;
      preset_wr = 1'b0; preset_din = '0;
      load_stb = 1'b0; zero_stb = 1'b0; flag_clr_stb = 1'b0; err_clr_stb = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      chk("R1", "count after reset", count_o, 0);
      chk("R1", "carry after reset", carry_o, 0);
      chk("R1", "borrow after reset", borrow_o, 0);
      chk("R1", "dir after reset", dir_up_o, 0);
      chk("R1", "noise after reset", noise_err_o, 0);

      // table: counting functions R2 R3 R4 R5, direction R10
      for (int i = 0; i < NVEC; i++) begin
         v = VEC[i];
         @(negedge clk);
         mode_cfg = {v[28:27], 2'b00};
         drive_ab(v[26], v[25]);
         if (v[29]) strobe(0);
         chk(req_of(v[28:27]), $sformatf("table row %0d count", i), count_o, 32'(v[24:1]));
         if (!v[29]) chk("R10", $sformatf("table row %0d dir", i), dir_up_o, 32'(v[0]));
      end
      pos = 2'd0;

      // R6 free-running wrap, 25th bit, flag clear
      mode_cfg = {2'b11, 2'd0};
      strobe(2);
      chk("R6", "flags cleared", {carry_o, borrow_o}, 0);
      write_preset(24'hFFFFFE);
      strobe(1);
      chk("R6", "load preset", count_o, 32'hFFFFFE);
      step(1);
      chk("R6", "count at max", count_o, 32'hFFFFFF);
      step(1);
      chk("R6", "wrap up count", count_o, 0);
      chk("R6", "carry after wrap", carry_o, 1);
      chk("R6", "bit 24 after wrap", carry_o ^ borrow_o, 1);
      step(0);
      chk("R6", "wrap down count", count_o, 32'hFFFFFF);
      chk("R6", "borrow after wrap", borrow_o, 1);
      chk("R6", "bit 24 back to 0", carry_o ^ borrow_o, 0);
      strobe(2);
      chk("R6", "flags cleared again", {carry_o, borrow_o}, 0);

      // R7 clamp
      mode_cfg = {2'b11, 2'd1};
      write_preset(24'd5);
      strobe(1);
      step(1);
      chk("R7", "clamp holds at preset", count_o, 5);
      chk("R7", "carry on blocked up", carry_o, 1);
      chk("R10", "dir after blocked up", dir_up_o, 1);
      strobe(0);
      step(0);
      chk("R7", "clamp holds at zero", count_o, 0);
      chk("R7", "borrow on blocked down", borrow_o, 1);
      step(1);
      chk("R7", "clamp counts inside range", count_o, 1);

      // R9 modulo
      mode_cfg = {2'b11, 2'd3};
      strobe(2);
      write_preset(24'd3);
      strobe(0);
      step(1); step(1); step(1);
      chk("R9", "count reaches preset", count_o, 3);
      step(1);
      chk("R9", "wrap to zero", count_o, 0);
      chk("R9", "carry on wrap", carry_o, 1);
      step(0);
      chk("R9", "wrap to preset", count_o, 3);
      chk("R9", "borrow on wrap", borrow_o, 1);

      // R8 one-shot
      mode_cfg = {2'b11, 2'd2};
      strobe(2);
      write_preset(24'hFFFFFF);
      strobe(1);
      step(1);
      chk("R8", "first wrap", count_o, 0);
      chk("R8", "carry on first wrap", carry_o, 1);
      step(1);
      chk("R8", "frozen on up", count_o, 0);
      step(0);
      chk("R8", "frozen on down", count_o, 0);
      chk("R8", "carry unchanged while frozen", carry_o, 1);
      strobe(1);
      chk("R8", "reload", count_o, 32'hFFFFFF);
      step(1);
      chk("R8", "wrap after reload", count_o, 0);
      chk("R8", "carry toggled back", carry_o, 0);
      strobe(0);
      step(1);
      chk("R8", "zero strobe unfreezes", count_o, 1);

      // R11 phase inputs disabled
      mode_cfg = {2'b11, 2'd0};
      strobe(0);
      chk("R1", "zero strobe", count_o, 0);
      io_cfg = 2'b10;
      step(1); step(1);
      chk("R11", "no count when disabled", count_o, 0);
      io_cfg = 2'b11;
      step(1);
      chk("R11", "counts when enabled", count_o, 1);

      // R14 simultaneous change
      strobe(0);
      pos = pos + 2'd2;
      drive_ab(pos[0] ^ pos[1], pos[1]);
      chk("R14", "no step on double change", count_o, 0);
      chk("R14", "noise flag set", noise_err_o, 1);
      step(1);
      chk("R14", "normal step still counts", count_o, 1);
      chk("R14", "noise flag sticky", noise_err_o, 1);
      strobe(3);
      chk("R14", "noise flag cleared", noise_err_o, 0);

      // R12 index preset load
      write_preset(24'h123456);
      io_cfg = 2'b01;
      idx_cfg = 2'b10;
      strobe(0);
      drive_idx(1'b1);
      chk("R12", "rising index loads", count_o, 32'h123456);
      strobe(0);
      drive_idx(1'b0);
      chk("R12", "falling index ignored", count_o, 0);
      idx_cfg = 2'b00;
      drive_idx(1'b1);
      chk("R12", "rising ignored for falling polarity", count_o, 0);
      drive_idx(1'b0);
      chk("R12", "falling index loads", count_o, 32'h123456);
      strobe(0);
      io_cfg = 2'b11;
      drive_idx(1'b1);
      drive_idx(1'b0);
      chk("R12", "index ignored when load disabled", count_o, 0);

      // R13 synchronous index
      io_cfg = 2'b01;
      idx_cfg = 2'b11;
      while (pos != 2'd1) step(1);
      strobe(0);
      drive_idx(1'b1);
      chk("R13", "no load off phase 00", count_o, 0);
      drive_idx(1'b0);
      while (pos != 2'd0) step(1);
      strobe(0);
      drive_idx(1'b1);
      chk("R13", "load on phase 00", count_o, 32'h123456);
      drive_idx(1'b0);
      mode_cfg = {2'b00, 2'd0};
      drive_ab(1'b1, 1'b0);
      pos = 2'd1;
      strobe(0);
      drive_idx(1'b1);
      chk("R13", "sync overridden in pulse mode", count_o, 32'h123456);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule